// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block owns the fetch address of a short in-order pipeline (fetch, decode, execute) whose branches are delayed. Each cycle, decode presents the branch fields of the instruction it holds: whether it is a branch, whether the branch is taken, whether its delay slot is executed or annulled, and a signed word offset. The block keeps the fetch PC and the PC of the instruction in decode. A dedicated adder forms the branch target from that decode PC, so the target fetch is issued in the cycle right after the delay slot is fetched.

A taken branch does not redirect fetch at once. The instruction after it (its delay slot) is always fetched first. When that delay-slot instruction is itself a taken branch, exactly one instruction at the first target is fetched. That instruction acts as the second branch's delay slot, and fetch then moves on to the second target. A branch decoded in a delay slot is flagged, because software must not depend on that sequencing. Annulled instructions are still fetched. A registered squash flag marks each one when it reaches execute, and an annulled instruction never acts as a branch.

Top module: `dbranch_fetch_seq`

## Requirements
- R1: While reset_n is low, fetch_pc equals the parameter RESET_VEC (default 0x1000) and ex_squash and slot_hazard are 0. This holds asynchronously, even in the middle of a run.
- R2: In an active (not stalled) cycle with no taken branch in decode, fetch_pc advances by 4 on the next clock. A not-taken branch never sets ex_squash.
- R3: A taken branch is decoded in an active cycle T, when fetch_pc already holds branch address + 4 (the delay slot). In cycle T+1, fetch_pc equals branch address + (sign-extended br_offset × 4).
- R4: dec_keep_slot = 0 on a taken branch marks its delay slot as annulled. ex_squash is 1 in the second active cycle after the branch's decode cycle, when the slot is in execute, and 0 in the next active cycle.
- R5: If the delay slot of a taken branch B1 is a taken branch B2, the next fetch after B2's decode cycle is B2's target. The single instruction fetched at B1's target just before it runs as B2's delay slot.
- R6: If B2 in R5 has dec_keep_slot = 0, the visited instruction at B1's target is squashed: ex_squash is 1 two active cycles after B2's decode cycle.
- R7: slot_hazard is 1 in the active cycle after a non-annulled branch (dec_is_branch = 1) is decoded in the delay slot of any non-annulled branch, and 0 otherwise.
- R8: Branch fields presented while an annulled instruction is in decode have no effect. Fetch continues by +4 and slot_hazard stays 0.
- R9: While stall is 1, fetch_pc, ex_squash and slot_hazard hold, and the decode fields are ignored. A branch presented in the first active cycle after a stall redirects as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| reset_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stall | input | 1 | Freezes the sequencer for this cycle |
| dec_is_branch | input | 1 | Instruction in decode is a branch |
| dec_taken | input | 1 | The branch in decode is taken |
| dec_keep_slot | input | 1 | 1 executes the delay slot, 0 annuls it (only if taken) |
| dec_offset | input | OFF_W | Signed word offset of the branch target |
| fetch_pc | output | ADDR_W | Address fetched this cycle |
| ex_squash | output | 1 | Instruction now in execute is annulled |
| slot_hazard | output | 1 | A branch sat in a delay slot in the previous active cycle |

## Verification
Runs of plain sequential fetch and not-taken branches show that fetch advances without redirect or squash. Isolated taken branches, with positive and negative offsets and both slot modes, separate a correct delay-slot target from a redirect that comes one cycle early and from a wrong squash. Back-to-back taken branches, with the second one executing and then annulling its slot, check that exactly one instruction is fetched at the first target and then skipped or squashed. A branch placed in an annulled slot, stalls held across pending branches, and a long pseudo-random stream compared each clock against a history-based model cover the remaining orderings.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  // bytes per instruction word and the matching shift
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_SHIFT = 2;

  // per-stage tracking bits for the instruction held in decode
  typedef struct packed {
    logic live;   // decode holds a real fetched instruction
    logic annul;  // that instruction is an annulled delay slot
    logic slot;   // that instruction is the delay slot of a branch
  } dec_track_t;
endpackage

// File: rtl/dbf_target_adder.sv
module dbf_target_adder #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base_pc,
  input  logic [OFF_W-1:0]  word_off,
  output logic [ADDR_W-1:0] target_pc
);
  import dbf_pkg::*;

  localparam int unsigned EXT_W = ADDR_W - OFF_W - WORD_SHIFT;

  logic [ADDR_W-1:0] byte_off;

  always_comb begin
    byte_off  = {{EXT_W{word_off[OFF_W-1]}}, word_off, {WORD_SHIFT{1'b0}}};
    target_pc = base_pc + byte_off;
  end
endmodule

// File: rtl/dbf_slot_tracker.sv
module dbf_slot_tracker (
  input  logic clk,
  input  logic reset_n,
  input  logic stall,
  input  logic br_is,
  input  logic br_taken,
  input  logic br_keep,
  output logic redirect,
  output logic ex_squash,
  output logic slot_hazard
);
  import dbf_pkg::*;

  dec_track_t trk_q, trk_n;
  logic       squash_q, squash_n;
  logic       hazard_q, hazard_n;
  logic       effective;

  // next-state logic
  always_comb begin
    effective       = trk_q.live & br_is & ~trk_q.annul;
    redirect        = effective & br_taken;
    trk_n.live      = 1'b1;
    trk_n.annul     = redirect & ~br_keep;
    trk_n.slot      = effective;
    squash_n        = trk_q.annul;
    hazard_n        = effective & trk_q.slot;
  end

  // state registers with explicit enable
  always_ff @(posedge clk or negedge reset_n) begin
    if (!reset_n) begin
      trk_q    <= '0;
      squash_q <= 1'b0;
      hazard_q <= 1'b0;
    end else if (!stall) begin
      trk_q    <= trk_n;
      squash_q <= squash_n;
      hazard_q <= hazard_n;
    end
  end

  assign ex_squash   = squash_q;
  assign slot_hazard = hazard_q;

  // R8
  annul_no_redirect_chk: assert property (@(posedge clk) disable iff (!reset_n)
    trk_q.annul |-> !redirect);

  // R4
  squash_spacing_chk: assert property (@(posedge clk) disable iff (!reset_n)
    (!stall && ex_squash) |=> !ex_squash);
endmodule

// File: rtl/dbf_pc_reg.sv
module dbf_pc_reg #(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              reset_n,
  input  logic              stall,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] target_pc,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic [ADDR_W-1:0] dec_pc
);
  import dbf_pkg::*;

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] fpc_q, fpc_n;
  logic [ADDR_W-1:0] dpc_q, dpc_n;

  always_comb begin
    fpc_n = redirect ? target_pc : (fpc_q + STEP);
    dpc_n = fpc_q;
  end

  always_ff @(posedge clk or negedge reset_n) begin
    if (!reset_n) begin
      fpc_q <= RESET_VEC;
      dpc_q <= '0;
    end else if (!stall) begin
      fpc_q <= fpc_n;
      dpc_q <= dpc_n;
    end
  end

  assign fetch_pc = fpc_q;
  assign dec_pc   = dpc_q;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!reset_n)
    stall |=> $stable(fetch_pc));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!reset_n)
    (!stall && !redirect) |=> fetch_pc == $past(fetch_pc) + STEP);
endmodule

// File: rtl/dbranch_fetch_seq.sv
module dbranch_fetch_seq #(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       OFF_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              reset_n,
  input  logic              stall,
  input  logic              dec_is_branch,
  input  logic              dec_taken,
  input  logic              dec_keep_slot,
  input  logic [OFF_W-1:0]  dec_offset,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic              ex_squash,
  output logic              slot_hazard
);
  import dbf_pkg::*;

  logic              redirect;
  logic [ADDR_W-1:0] dec_pc;
  logic [ADDR_W-1:0] target_pc;

  dbf_target_adder #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_adder (
    .base_pc  (dec_pc),
    .word_off (dec_offset),
    .target_pc(target_pc)
  );

  dbf_slot_tracker u_track (
    .clk        (clk),
    .reset_n    (reset_n),
    .stall      (stall),
    .br_is      (dec_is_branch),
    .br_taken   (dec_taken),
    .br_keep    (dec_keep_slot),
    .redirect   (redirect),
    .ex_squash  (ex_squash),
    .slot_hazard(slot_hazard)
  );

  dbf_pc_reg #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_pc (
    .clk      (clk),
    .reset_n  (reset_n),
    .stall    (stall),
    .redirect (redirect),
    .target_pc(target_pc),
    .fetch_pc (fetch_pc),
    .dec_pc   (dec_pc)
  );

  // R3
  target_align_chk: assert property (@(posedge clk) disable iff (!reset_n)
    (!stall && redirect) |=> fetch_pc[WORD_SHIFT-1:0] == RESET_VEC[WORD_SHIFT-1:0]);
endmodule

// File: tb/dbranch_fetch_seq_bench.sv
`timescale 1ns/1ps
module dbranch_fetch_seq_bench;
  localparam logic [31:0] RV = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        reset_n = 1'b0;
  logic        stall = 1'b0;
  logic        dec_is_branch = 1'b0;
  logic        dec_taken = 1'b0;
  logic        dec_keep_slot = 1'b0;
  logic [15:0] dec_offset = '0;
  logic [31:0] fetch_pc;
  logic        ex_squash;
  logic        slot_hazard;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // history model: index = active-cycle number since reset
  logic [31:0] fa  [0:255];
  bit          ann [0:255];
  bit          slt [0:255];
  int          k;
  bit          m_sq, m_hz;

  always #2.5 clk = ~clk;

  dbranch_fetch_seq u_dbranch_fetch_seq (
    .clk(clk), .reset_n(reset_n), .stall(stall),
    .dec_is_branch(dec_is_branch), .dec_taken(dec_taken),
    .dec_keep_slot(dec_keep_slot), .dec_offset(dec_offset),
    .fetch_pc(fetch_pc), .ex_squash(ex_squash), .slot_hazard(slot_hazard)
  );

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s fetch_pc act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    k = 0;
    fa[0] = RV;
    m_sq = 1'b0;
    m_hz = 1'b0;
  endtask

  // one clock: drive, update model, sample at the falling edge, compare
  task automatic step(input bit v, input bit t, input bit e, input int off,
                      input bit st, input string tag);
    bit eff, take;
    int cur, prv;
    stall = st; dec_is_branch = v; dec_taken = t; dec_keep_slot = e;
    dec_offset = off[15:0];
    if (!st) begin
      cur  = k & 255;
      prv  = (k - 1) & 255;
      eff  = (k >= 1) && v && !ann[prv];
      take = eff && t;
      ann[cur] = take && !e;
      slt[cur] = eff;
      m_hz = eff && (k >= 1) && slt[prv];
      m_sq = (k >= 1) ? ann[prv] : 1'b0;
      fa[(k + 1) & 255] = take ? (fa[prv] + 32'(off * 4)) : (fa[cur] + 32'd4);
      k++;
    end
    @(posedge clk);
    @(negedge clk);
    chk32(tag, fetch_pc, fa[k & 255]);
    chk1(tag, "ex_squash", ex_squash, m_sq);
    chk1(tag, "slot_hazard", slot_hazard, m_hz);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    // R1 reset state
    chk32("R1", fetch_pc, RV);
    chk1("R1", "ex_squash", ex_squash, 1'b0);
    chk1("R1", "slot_hazard", slot_hazard, 1'b0);
    reset_n = 1'b1;
    model_reset();

    step(0, 0, 0, 0, 0, "R2");
    chk32("R2", fetch_pc, 32'h1004);
    step(0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 5, 0, "R2");               // not-taken branch at 0x1004
    chk32("R2", fetch_pc, 32'h100C);
    step(0, 0, 0, 0, 0, "R2");
    chk1("R2", "ex_squash", ex_squash, 1'b0);
    step(1, 1, 1, 4, 0, "R3");               // branch at 0x100C -> 0x101C
    chk32("R3", fetch_pc, 32'h101C);
    step(0, 0, 0, 0, 0, "R3");
    step(1, 1, 0, -2, 0, "R4");              // branch at 0x101C -> 0x1014, annul slot 0x1020
    chk32("R3", fetch_pc, 32'h1014);
    step(0, 0, 0, 0, 0, "R4");
    chk1("R4", "ex_squash", ex_squash, 1'b1);
    step(0, 0, 0, 0, 0, "R4");
    chk1("R4", "ex_squash", ex_squash, 1'b0);
    step(1, 1, 1, 64, 0, "R5");              // B1 at 0x1018 -> 0x1118
    chk32("R5", fetch_pc, 32'h1118);
    step(1, 1, 1, 16, 0, "R5");              // B2 in slot at 0x101C -> 0x105C
    chk32("R5", fetch_pc, 32'h105C);
    chk1("R7", "slot_hazard", slot_hazard, 1'b1);
    step(0, 0, 0, 0, 0, "R7");
    chk1("R7", "slot_hazard", slot_hazard, 1'b0);
    step(1, 1, 1, 8, 0, "R6");               // B1 at 0x105C -> 0x107C
    step(1, 1, 0, -4, 0, "R6");              // B2 annulling -> 0x1050
    chk32("R6", fetch_pc, 32'h1050);
    step(1, 1, 1, 40, 0, "R8");              // fields on annulled 0x107C ignored
    chk32("R8", fetch_pc, 32'h1054);
    chk1("R8", "slot_hazard", slot_hazard, 1'b0);
    chk1("R6", "ex_squash", ex_squash, 1'b1);
    step(1, 1, 1, 100, 1, "R9");             // stalled: no change
    chk32("R9", fetch_pc, 32'h1054);
    chk1("R9", "ex_squash", ex_squash, 1'b1);
    step(1, 1, 1, 3, 0, "R9");               // branch at 0x1050 -> 0x105C
    chk32("R9", fetch_pc, 32'h105C);
    step(0, 0, 0, 0, 0, "R2");

    // R1 asynchronous reset in mid-run
    reset_n = 1'b0;
    #1;
    chk32("R1", fetch_pc, RV);
    chk1("R1", "ex_squash", ex_squash, 1'b0);
    chk1("R1", "slot_hazard", slot_hazard, 1'b0);
    @(negedge clk);
    reset_n = 1'b1;
    model_reset();

    for (int i = 0; i < 4000; i++) begin
      bit v, t, e, st;
      int off;
      v   = ($urandom_range(0, 9) < 4);
      t   = ($urandom_range(0, 3) != 0);
      e   = $urandom_range(0, 1) == 1;
      st  = ($urandom_range(0, 99) < 15);
      off = int'($urandom_range(0, 127)) - 64;
      step(v, t, e, off, st, "R5");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule